// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block carries out one I2C master transaction each time the host sets a start request. The bytes to send come from an external transmit queue: the first entry is always the address byte (7-bit target address in bits 7:1, direction flag in bit 0), and a write carries on until it has sent an entry marked as final. A read fetches a programmed number of bytes and hands each one to an external receive queue. The queues themselves live outside the block.

The bus pins are open-drain. The block only produces pull-low enables for SCL and SDA and reads the resolved SDA level back. The bit rate comes from a speed-select input that is latched at launch: standard or fast, each a parameterised half-period in clock cycles. When a transaction ends, busy drops and a 3-bit completion code is left on the status output until the next launch. The code tells success apart from lost arbitration, an unacknowledged address, an unacknowledged data byte, and a transmit-queue stall timeout. A hold input puts the controller back into its reset state, and an enable input gates new launches.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0 and `status` is 0. `go` with `enable`=1 and a valid command raises `busy` on the next cycle. `busy` stays high until the transaction ends. Whenever `busy` is low, `status` holds the code of the last transaction: 0 success, 1 lost arbitration, 2 address NACK, 3 data NACK, 4 stall timeout.
- R2: The first transmit entry is popped as the address byte and shifted out MSB first. `tx_pop` is only asserted while `tx_empty` is 0.
- R3: With `proto`=7 (block write), data entries are sent MSB first, each followed by an acknowledge slot. The transaction finishes with code 0 after the entry whose `tx_last` bit is set has been acknowledged.
- R4: With `proto`=8 (block read), `rd_count` bytes are received MSB first, and each is pushed on `rx_push`/`rx_data`. The master acknowledges (pulls SDA low) every byte except the last one, which it leaves unacknowledged.
- R5: A launch is ignored, with no bus activity, no pop and no change to `busy` or `status`, when `enable` is 0, when `proto` is neither 7 nor 8, or when a read has `rd_count` of 0 or above 63.
- R6: An address byte left unacknowledged ends the transaction with code 2, followed by a STOP.
- R7: A data byte left unacknowledged ends the transaction with code 3 and a STOP. No further entries are popped.
- R8: If SDA reads low at the sampling point of a bit that the master is sending as 1, the master releases both lines at once and ends with code 1, without a STOP. With standard speed and the default parameters, losing on the second address bit takes exactly 6*HALF_STD+2 busy cycles.
- R9: When the transmit queue is empty at a byte boundary, the master holds SCL low and raises `underrun_req`. If no entry arrives within STALL_LIMIT cycles, the transaction ends with code 4 and a STOP.
- R10: Every SCL high phase of a bit lasts HALF_FAST cycles when `fast` was 1 at launch, and HALF_STD cycles otherwise.
- R11: `hold`=1 returns the controller to its reset state on the next cycle: `busy` 0, `status` 0, both lines released.
- R12: Every transaction except one lost to arbitration ends with a STOP condition: SDA released while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Holds the controller in its reset state |
| enable | input | 1 | Allows new launches |
| fast | input | 1 | Speed select, latched at launch: 1 fast, 0 standard |
| go | input | 1 | Start request, one cycle |
| proto | input | 4 | Protocol: 7 block write, 8 block read |
| rd_count | input | 8 | Number of bytes to read (1..63) |
| busy | output | 1 | Transaction in progress |
| status | output | 3 | Completion code of the last transaction |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | 8 | Head entry byte |
| tx_last | input | 1 | Head entry is the final byte of a write |
| tx_pop | output | 1 | Consume head entry |
| underrun_req | output | 1 | Write stalled for lack of data |
| rx_push | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA level |

## Verification
A behavioural target model on the bench bus is driven with random mixes of writes and reads of random length, at both speeds. This separates correct byte order, acknowledge handling and phase timing from corruption that only shows up on some lengths or speeds. Directed cases follow: a wrong target address, a NACK on the second data byte, a competing driver holding SDA low, a queue that runs dry, and a hold in mid-transfer. Each of these yields a distinct completion code, pop count and transaction length, so a mix-up between the error paths is visible. Reads of 1 and 63 bytes check the acknowledge pattern at both ends of the count range, and malformed launches confirm that nothing moves on the bus.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;

    localparam logic [3:0] PROTO_WR = 4'd7;
    localparam logic [3:0] PROTO_RD = 4'd8;

    typedef enum logic [3:0] {
        S_IDLE, S_ST0, S_ST1, S_LOAD, S_LOW, S_HIGH,
        S_SP0, S_SP1, S_SP2, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        CODE_OK       = 3'd0,
        CODE_ARB      = 3'd1,
        CODE_NACK_ADR = 3'd2,
        CODE_NACK_DAT = 3'd3,
        CODE_TMO      = 3'd4
    } done_code_e;

    typedef struct packed {
        logic [7:0] shreg;     // bit in flight sits in bit 7
        logic [3:0] slot;      // 0..7 data bits, 8 acknowledge slot
        logic       rx_mode;   // receiving bytes from the target
        logic       addr_ph;   // current byte is the address byte
        logic       last_tag;  // current write byte is the final one
    } byte_eng_t;

    // States whose duration is one half bit period
    function automatic logic is_timed(seq_state_e s);
        return (s == S_ST0) || (s == S_ST1) || (s == S_LOW) || (s == S_HIGH) ||
               (s == S_SP0) || (s == S_SP1) || (s == S_SP2);
    endfunction

endpackage

// File: rtl/i2c_cmd_seq_tick.sv
module i2c_cmd_seq_tick #(
    parameter int HALF_STD  = 8,
    parameter int HALF_FAST = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fast,
    output logic tick
);
    localparam int LMAX = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
    localparam int CW   = $clog2(LMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(HALF_FAST - 1) : CW'(HALF_STD - 1);
    assign tick = !clear && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clear || tick) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_cmd_seq_wdog.sv
module i2c_cmd_seq_wdog #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (!expire) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cmd_seq_pkg::*;
#(
    parameter int HALF_STD    = 8,
    parameter int HALF_FAST   = 2,
    parameter int STALL_LIMIT = 200,
    parameter int MAX_RD      = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       enable,
    input  logic       fast,
    input  logic       go,
    input  logic [3:0] proto,
    input  logic [7:0] rd_count,
    output logic       busy,
    output logic [2:0] status,
    input  logic       tx_empty,
    input  logic [7:0] tx_data,
    input  logic       tx_last,
    output logic       tx_pop,
    output logic       underrun_req,
    output logic       rx_push,
    output logic [7:0] rx_data,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    seq_state_e state_q, state_d;
    byte_eng_t  eng_q, eng_d;
    done_code_e pend_q, pend_d;
    logic       rd_q, rd_d, fast_q, fast_d;
    logic [7:0] left_q, left_d;
    logic [2:0] code_q, code_d;
    logic       rst_any, tick, stall, expire, launch_ok, drv_low;

    assign rst_any = rst || hold;
    assign stall   = (state_q == S_LOAD) && tx_empty;

    i2c_cmd_seq_tick #(.HALF_STD(HALF_STD), .HALF_FAST(HALF_FAST)) u_tick (
        .clk(clk), .rst(rst_any), .clear(!is_timed(state_q)),
        .fast(fast_q), .tick(tick)
    );

    i2c_cmd_seq_wdog #(.LIMIT(STALL_LIMIT)) u_wdog (
        .clk(clk), .rst(rst_any), .run(stall), .expire(expire)
    );

    assign launch_ok = enable && go &&
        ((proto == PROTO_WR) ||
         ((proto == PROTO_RD) && (rd_count != 8'd0) && (int'(rd_count) <= MAX_RD)));

    // Pull SDA low for a 0 data bit we send, or for an ACK we give
    always_comb begin
        if (eng_q.slot != 4'd8) drv_low = !eng_q.rx_mode && !eng_q.shreg[7];
        else                    drv_low = eng_q.rx_mode && (left_q != 8'd1);
    end

    assign busy         = (state_q != S_IDLE);
    assign status       = code_q;
    assign tx_pop       = (state_q == S_LOAD) && !tx_empty;
    assign underrun_req = stall;
    assign scl_oe       = (state_q == S_LOAD) || (state_q == S_LOW) || (state_q == S_SP0);
    assign sda_oe       = (state_q == S_ST1) || (state_q == S_SP0) || (state_q == S_SP1) ||
                          (((state_q == S_LOW) || (state_q == S_HIGH)) && drv_low);
    assign rx_push      = (state_q == S_HIGH) && tick && eng_q.rx_mode && (eng_q.slot == 4'd7);
    assign rx_data      = {eng_q.shreg[6:0], sda_in};

    always_comb begin
        state_d = state_q;
        eng_d   = eng_q;
        pend_d  = pend_q;
        rd_d    = rd_q;
        fast_d  = fast_q;
        left_d  = left_q;
        code_d  = code_q;
        case (state_q)
            S_IDLE: if (launch_ok) begin
                state_d = S_ST0;
                rd_d    = (proto == PROTO_RD);
                left_d  = rd_count;
                fast_d  = fast;
                pend_d  = CODE_OK;
            end
            S_ST0: if (tick) state_d = S_ST1;
            S_ST1: if (tick) begin
                state_d       = S_LOAD;
                eng_d.addr_ph = 1'b1;
                eng_d.rx_mode = 1'b0;
            end
            S_LOAD: begin
                if (!tx_empty) begin
                    eng_d.shreg    = tx_data;
                    eng_d.last_tag = tx_last;
                    eng_d.slot     = 4'd0;
                    state_d        = S_LOW;
                end else if (expire) begin
                    pend_d  = CODE_TMO;
                    state_d = S_SP0;
                end
            end
            S_LOW: if (tick) state_d = S_HIGH;
            S_HIGH: if (tick) begin
                if (eng_q.slot != 4'd8) begin
                    if (!eng_q.rx_mode && eng_q.shreg[7] && !sda_in) begin
                        pend_d  = CODE_ARB;
                        state_d = S_DONE;
                    end else begin
                        eng_d.shreg = {eng_q.shreg[6:0], sda_in};
                        eng_d.slot  = eng_q.slot + 4'd1;
                        state_d     = S_LOW;
                    end
                end else if (!eng_q.rx_mode) begin
                    if (sda_in) begin
                        pend_d  = eng_q.addr_ph ? CODE_NACK_ADR : CODE_NACK_DAT;
                        state_d = S_SP0;
                    end else if (eng_q.addr_ph && rd_q) begin
                        eng_d.rx_mode = 1'b1;
                        eng_d.addr_ph = 1'b0;
                        eng_d.slot    = 4'd0;
                        state_d       = S_LOW;
                    end else if (eng_q.last_tag) begin
                        state_d = S_SP0;
                    end else begin
                        eng_d.addr_ph = 1'b0;
                        state_d       = S_LOAD;
                    end
                end else begin
                    left_d     = left_q - 8'd1;
                    eng_d.slot = 4'd0;
                    state_d    = (left_q == 8'd1) ? S_SP0 : S_LOW;
                end
            end
            S_SP0: if (tick) state_d = S_SP1;
            S_SP1: if (tick) state_d = S_SP2;
            S_SP2: if (tick) state_d = S_DONE;
            S_DONE: begin
                code_d  = pend_q;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            state_q <= S_IDLE;
            eng_q   <= '0;
            pend_q  <= CODE_OK;
            rd_q    <= 1'b0;
            fast_q  <= 1'b0;
            left_q  <= 8'd0;
            code_q  <= 3'd0;
        end else begin
            state_q <= state_d;
            eng_q   <= eng_d;
            pend_q  <= pend_d;
            rd_q    <= rd_d;
            fast_q  <= fast_d;
            left_q  <= left_d;
            code_q  <= code_d;
        end
    end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hold,
    input logic       busy,
    input logic [2:0] status,
    input logic       tx_empty,
    input logic       tx_pop,
    input logic       underrun_req,
    input logic       rx_push,
    input logic       scl_oe,
    input logic       sda_oe
);
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(hold)) |-> $stable(status)); // R1
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        status <= 3'd4); // R1
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty); // R2
    AST_RX_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (busy && !tx_pop)); // R4
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe)); // R5
    AST_STALL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        underrun_req |-> (scl_oe && !tx_pop && busy)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!busy && status == 3'd0)); // R11
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .hold(hold), .busy(busy), .status(status),
    .tx_empty(tx_empty), .tx_pop(tx_pop), .underrun_req(underrun_req),
    .rx_push(rx_push), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_cmd_seq_tb.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb;
    localparam int HS = 8;
    localparam int HF = 2;
    localparam int SL = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold = 1'b0, enable = 1'b0, fast = 1'b0, go = 1'b0;
    logic [3:0] proto = 4'd0;
    logic [7:0] rd_count = 8'd0;
    logic busy, tx_pop, underrun_req, rx_push, scl_oe, sda_oe;
    logic [2:0] status;
    logic [7:0] rx_data;
    logic tx_empty, tx_last, sda_in;
    logic [7:0] tx_data;

    always #2 clk = ~clk;

    // transmit queue model
    logic [8:0] txq [0:127];
    int txh = 0, txt = 0;
    logic tx_clr = 1'b0;
    assign tx_empty = (txh == txt);
    assign tx_data  = txq[txh[6:0]][7:0];
    assign tx_last  = txq[txh[6:0]][8];
    always @(posedge clk) begin
        if (tx_clr)      txh <= txt;
        else if (tx_pop) txh <= txh + 1;
    end

    // receive log
    logic [7:0] rxlog [0:127];
    int rxn = 0;
    logic rx_clr = 1'b0;
    always @(posedge clk) begin
        if (rx_clr) rxn <= 0;
        else if (rx_push) begin
            rxlog[rxn[6:0]] <= rx_data;
            rxn <= rxn + 1;
        end
    end

    // open-drain bus
    logic s_drv = 1'b0, comp_drv = 1'b0;
    wire sda_line = !(sda_oe || s_drv || comp_drv);
    wire scl_line = !scl_oe;
    assign sda_in = sda_line;

    i2c_cmd_seq u_dut (
        .clk(clk), .rst(rst), .hold(hold), .enable(enable), .fast(fast), .go(go),
        .proto(proto), .rd_count(rd_count), .busy(busy), .status(status),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_last(tx_last), .tx_pop(tx_pop),
        .underrun_req(underrun_req), .rx_push(rx_push), .rx_data(rx_data),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // target model
    logic [6:0] slv_addr = 7'h2C;
    int nack_at = -1;
    logic [7:0] rd_key = 8'h3C;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic s_act = 1'b0, s_rw = 1'b0, s_quit = 1'b0;
    logic [7:0] s_sh = 8'd0, s_abyte = 8'd0, tmpb;
    int s_cnt = 0, s_byte = 0, s_rcvn = 0, s_stops = 0, s_macks = 0, s_mnacks = 0;
    logic [7:0] rcv [0:127];

    function automatic logic [7:0] rd_pat(input int i);
        logic [7:0] v;
        v = 8'(i * 29 + 91);
        return v ^ rd_key;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            s_act = 1'b0; s_drv = 1'b0;
        end else begin
            if (p_scl && scl_line && p_sda && !sda_line) begin
                s_act = 1'b1; s_cnt = 0; s_byte = 0; s_rcvn = 0; s_drv = 1'b0;
                s_rw = 1'b0; s_quit = 1'b0; s_macks = 0; s_mnacks = 0;
            end else if (p_scl && scl_line && !p_sda && sda_line) begin
                s_act = 1'b0; s_drv = 1'b0; s_stops = s_stops + 1;
            end else if (s_act && !p_scl && scl_line) begin
                if (s_cnt < 8) s_sh = {s_sh[6:0], sda_line};
                else if (s_rw && s_byte > 0) begin
                    if (sda_line) begin s_quit = 1'b1; s_mnacks = s_mnacks + 1; end
                    else s_macks = s_macks + 1;
                end
                s_cnt = s_cnt + 1;
                if (s_cnt == 9) begin
                    s_cnt = 0;
                    if (s_byte == 0) s_abyte = s_sh;
                    else if (!s_rw) begin rcv[s_rcvn[6:0]] = s_sh; s_rcvn = s_rcvn + 1; end
                    s_byte = s_byte + 1;
                end
            end else if (s_act && p_scl && !scl_line) begin
                s_drv = 1'b0;
                if (s_cnt == 8) begin
                    if (s_byte == 0) begin
                        s_rw  = s_sh[0];
                        s_drv = (s_sh[7:1] == slv_addr);
                    end else if (!s_rw) s_drv = ((s_byte - 1) != nack_at);
                end else if (s_rw && s_byte > 0 && !s_quit) begin
                    tmpb  = rd_pat(s_byte - 1);
                    s_drv = !tmpb[7 - s_cnt];
                end
            end
            p_scl = scl_line;
            p_sda = sda_line;
        end
    end

    // bus monitor: shortest SCL high phase in a transaction, activity count
    int hi_run = 0, min_hi = 999, act_n = 0;
    always @(negedge clk) begin
        if (go) min_hi = 999;
        if (!scl_oe) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0 && busy && hi_run < min_hi) min_hi = hi_run;
            hi_run = 0;
        end
        if (scl_oe || sda_oe) act_n = act_n + 1;
    end

    int nchk = 0, nfail = 0, cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: run did not end (act=%0d exp=0)", cyc);
            $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic last, input logic [7:0] d);
        txq[txt[6:0]] = {last, d};
        txt = txt + 1;
    endtask

    task automatic flush();
        @(negedge clk); tx_clr = 1'b1; rx_clr = 1'b1;
        @(negedge clk); tx_clr = 1'b0; rx_clr = 1'b0;
    endtask

    task automatic start_cmd(input logic [3:0] p, input int cnt, input logic f);
        @(negedge clk);
        proto = p; rd_count = 8'(cnt); fast = f; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done(output int bc);
        bc = 0;
        while (busy && bc < 40000) begin
            bc = bc + 1;
            @(negedge clk);
        end
    endtask

    logic [7:0] wdat [0:63];
    logic [6:0] tgt = 7'h2C;

    task automatic do_write(input int len, input logic f, output int bc);
        push(1'b0, {tgt, 1'b0});
        for (int i = 0; i < len; i++) push(i == len - 1, wdat[i]);
        start_cmd(4'd7, 0, f);
        wait_done(bc);
    endtask

    task automatic do_read(input int len, input logic f, output int bc);
        push(1'b0, {tgt, 1'b1});
        start_cmd(4'd8, len, f);
        wait_done(bc);
    endtask

    function automatic int wr_mism(input int len);
        int m = 0;
        for (int i = 0; i < len; i++) if (rcv[i] != wdat[i]) m++;
        return m;
    endfunction

    function automatic int rd_mism(input int len);
        int m = 0;
        for (int i = 0; i < len; i++) if (rxlog[i] != rd_pat(i)) m++;
        return m;
    endfunction

    int bc, st0, a0, h0, sc, len;
    logic f, rw;
    int unsigned sd;

    initial begin
        sd = $urandom(32'h51ED);
        repeat (4) @(negedge clk);
        rst = 1'b0; enable = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset lines", int'(scl_oe | sda_oe | tx_pop), 0);

        // directed write, standard speed
        wdat[0] = 8'hA5; wdat[1] = 8'h00; wdat[2] = 8'hFF;
        st0 = s_stops;
        do_write(3, 1'b0, bc);
        chk("R3 write status", int'(status), 0);
        chk("R3 write count", s_rcvn, 3);
        chk("R3 write data", wr_mism(3), 0);
        chk("R2 address byte", int'(s_abyte), 8'h58);
        chk("R10 std high phase", min_hi, HS);
        chk("R12 stop after write", s_stops - st0, 1);

        // read of a single byte, fast speed
        flush();
        do_read(1, 1'b1, bc);
        chk("R4 read1 status", int'(status), 0);
        chk("R4 read1 count", rxn, 1);
        chk("R4 read1 data", rd_mism(1), 0);
        chk("R4 read1 acks", s_macks, 0);
        chk("R4 read1 nack last", s_mnacks, 1);
        chk("R10 fast high phase", min_hi, HF);

        // read of 63 bytes
        flush();
        do_read(63, 1'b1, bc);
        chk("R4 read63 count", rxn, 63);
        chk("R4 read63 data", rd_mism(63), 0);
        chk("R4 read63 acks", s_macks, 62);
        chk("R4 read63 nacks", s_mnacks, 1);
        flush();

        // ignored launches
        push(1'b0, {tgt, 1'b0});
        a0 = act_n; h0 = txh;
        start_cmd(4'd3, 0, 1'b0); repeat (4) @(negedge clk);
        chk("R5 bad proto busy", int'(busy), 0);
        start_cmd(4'd8, 0, 1'b0); repeat (4) @(negedge clk);
        chk("R5 read count 0 busy", int'(busy), 0);
        start_cmd(4'd8, 64, 1'b0); repeat (4) @(negedge clk);
        chk("R5 read count 64 busy", int'(busy), 0);
        enable = 1'b0;
        start_cmd(4'd7, 0, 1'b0); repeat (4) @(negedge clk);
        enable = 1'b1;
        chk("R5 disabled busy", int'(busy), 0);
        chk("R5 no bus activity", act_n - a0, 0);
        chk("R5 no pop", txh - h0, 0);
        chk("R5 status kept", int'(status), 0);
        flush();

        // address NACK
        tgt = 7'h11; wdat[0] = 8'h12; wdat[1] = 8'h34;
        st0 = s_stops;
        do_write(2, 1'b0, bc);
        chk("R6 addr nack code", int'(status), 2);
        chk("R6 no data taken", s_rcvn, 0);
        chk("R12 stop after addr nack", s_stops - st0, 1);
        flush(); tgt = 7'h2C;

        // data NACK on second data byte
        nack_at = 1;
        for (int i = 0; i < 4; i++) wdat[i] = 8'(8'h40 + i);
        h0 = txh;
        do_write(4, 1'b1, bc);
        chk("R7 data nack code", int'(status), 3);
        chk("R7 pops stop", txh - h0, 3);
        chk("R7 bytes seen", s_rcvn, 2);
        flush(); nack_at = -1;

        // lost arbitration: competitor holds SDA low
        comp_drv = 1'b1; h0 = txh; st0 = s_stops;
        do_write(2, 1'b0, bc);
        chk("R8 arb code", int'(status), 1);
        chk("R8 arb length", bc, 6 * HS + 2);
        chk("R8 lines released", int'(scl_oe | sda_oe), 0);
        chk("R8 only address popped", txh - h0, 1);
        chk("R8 no stop", s_stops - st0, 0);
        comp_drv = 1'b0;
        flush();

        // stall timeout
        push(1'b0, {tgt, 1'b0}); push(1'b0, 8'h9A); push(1'b0, 8'hBC);
        st0 = s_stops;
        start_cmd(4'd7, 0, 1'b1);
        sc = 0;
        while (!underrun_req && sc < 20000) begin sc = sc + 1; @(negedge clk); end
        chk("R9 scl held during stall", int'(scl_oe & underrun_req), 1);
        sc = 0; bc = 0;
        while (busy && bc < 40000) begin
            if (underrun_req) sc = sc + 1;
            bc = bc + 1;
            @(negedge clk);
        end
        chk("R9 stall length", sc, SL);
        chk("R9 timeout code", int'(status), 4);
        chk("R9 bytes before stall", s_rcvn, 2);
        chk("R12 stop after timeout", s_stops - st0, 1);
        flush();

        // hold in mid-transfer
        for (int i = 0; i < 10; i++) wdat[i] = 8'(i * 7);
        push(1'b0, {tgt, 1'b0});
        for (int i = 0; i < 10; i++) push(i == 9, wdat[i]);
        start_cmd(4'd7, 0, 1'b0);
        repeat (100) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        hold = 1'b0;
        chk("R11 hold busy", int'(busy), 0);
        chk("R11 hold status", int'(status), 0);
        chk("R11 hold lines", int'(scl_oe | sda_oe), 0);
        flush();

        // random mix
        for (int t = 0; t < 24; t++) begin
            rw  = 1'($urandom);
            f   = 1'($urandom);
            len = 1 + int'($urandom % 8);
            st0 = s_stops;
            if (!rw) begin
                for (int i = 0; i < len; i++) wdat[i] = 8'($urandom);
                do_write(len, f, bc);
                chk("R3 rand write status", int'(status), 0);
                chk("R3 rand write data", wr_mism(len) + (s_rcvn != len ? 100 : 0), 0);
                chk("R2 rand address", int'(s_abyte), 8'h58);
            end else begin
                rd_key = 8'($urandom);
                do_read(len, f, bc);
                chk("R4 rand read status", int'(status), 0);
                chk("R4 rand read data", rd_mism(len) + (rxn != len ? 100 : 0), 0);
                chk("R4 rand read acks", s_macks, len - 1);
                chk("R2 rand address", int'(s_abyte), 8'h59);
            end
            chk("R10 rand high phase", min_hi, f ? HF : HS);
            chk("R12 rand stop", s_stops - st0, 1);
            flush();
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule